// File: doc/BRIEF.md
# Color correction matrix unit

This block multiplies every RGB pixel of a streaming video path by a programmable 3x3 matrix. Each output channel is the sum of three signed products of the input channels. The sum is rounded to an integer and clamped into the range of the configured output pixel depth. Pixels arrive and leave on a valid/ready handshake that also carries a start-of-frame marker. A fixed three-register pipeline does the arithmetic, and a stall at the output freezes every stage at once.

The matrix entries, an enable bit and a depth code are written one byte at a time over a simple write-only register bus. Each write lands in a shadow copy. The shadow copy becomes the working copy only when a start-of-frame pixel is accepted, so one frame is never processed with a mix of old and new settings. When the enable bit is clear, pixels pass through unchanged with the same latency.

Top module: `ccm_unit`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, all nine coefficients are zero and the enable bit is clear. Enabling the matrix without writing any coefficient therefore yields black pixels.
- R2: Coefficient k = 3*row + col (row = output channel, col = input channel, channel order R, G, B) is a signed 16-bit value scaled by 512 (bits 15:9 integer, bits 8:0 fraction). Its low byte is written at address 0xD0 + 2k and its high byte at 0xD1 + 2k, so the last byte is at 0xE1.
- R3: With the matrix enabled, output channel `row` equals the sum over col of coef[3*row+col] * in[col], using signed coefficients and unsigned pixels.
- R4: Before clamping, the sum is rounded by adding 256 and shifting right arithmetically by 9 bits.
- R5: A rounded result below zero becomes 0. A result above 2^d - 1 becomes 2^d - 1.
- R6: The output depth d is (N + 4) * 2 bits, where N is the 2-bit code written to bits 1:0 of address 0xE3. This gives 8, 10, 12 or 14 bits.
- R7: Bit 1 of address 0xE2 enables the matrix. When it is clear, each pixel is output unchanged, with no clamping.
- R8: Coefficient, enable and depth writes take effect starting with the next accepted start-of-frame pixel, and apply to that pixel too. Pixels accepted before it use the previous settings.
- R9: A pixel accepted at a rising edge is presented on the output after the second following rising edge, provided out_ready stays high. Its start-of-frame flag is presented with it.
- R10: While out_valid is high and out_ready is low, in_ready is low and every output holds its value.
- R11: A write to any address outside 0xD0 to 0xE3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write byte |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_r | input | 14 | Input red |
| in_g | input | 14 | Input green |
| in_b | input | 14 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_r | output | 14 | Output red |
| out_g | output | 14 | Output green |
| out_b | output | 14 | Output blue |

## Verification
The assertions rely on the following about the inputs:
- Reset is held for the first cycles of the run.
- Each register write is a single-cycle strobe with a stable address.
- out_ready may toggle in any cycle, and in_valid may drop without having been taken.

The stimulus keeps every matrix-mode input component within the depth in force for its frame. It changes settings only through byte writes, between pixels. It drives out_ready either high all the time or with a random three-in-four pattern, so stalls land on all pipeline stages.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    localparam int PIX_W          = 14;
    localparam int COEF_W         = 16;
    localparam int FRAC_W         = 9;
    localparam int MAT_N          = 3;
    localparam int N_COEF         = MAT_N * MAT_N;
    localparam int BUS_AW         = 8;
    localparam int BUS_DW         = 8;
    localparam int BYTES_PER_COEF = COEF_W / BUS_DW;
    localparam int N_COEF_BYTES   = N_COEF * BYTES_PER_COEF;
    localparam int PROD_W         = COEF_W + PIX_W + 1;
    localparam int SUM_W          = PROD_W + $clog2(MAT_N);
    localparam int DCODE_W        = 2;
    localparam int EN_BIT         = 1;

    localparam logic [BUS_AW-1:0] COEF_BASE  = 8'hD0;
    localparam logic [BUS_AW-1:0] CTRL_ADDR  = 8'hE2;
    localparam logic [BUS_AW-1:0] DEPTH_ADDR = 8'hE3;

    localparam logic signed [SUM_W:0] ROUND_ADD = (SUM_W + 1)'(1 << (FRAC_W - 1));

    typedef logic [PIX_W-1:0]          pix_t;
    typedef logic signed [COEF_W-1:0]  coef_t;
    typedef logic signed [PROD_W-1:0]  prod_t;
    typedef logic signed [SUM_W-1:0]   sum_t;
    typedef logic [DCODE_W-1:0]        dcode_t;

    typedef struct packed {
        pix_t r;
        pix_t g;
        pix_t b;
    } rgb_t;

    typedef struct packed {
        logic                    en;
        dcode_t                  dcode;
        coef_t [N_COEF-1:0]      m;
    } cfg_t;

    typedef struct packed {
        logic v;
        logic sof;
        logic en;
        pix_t mx;
        rgb_t raw;
    } meta_t;

    function automatic int unsigned depth_bits(dcode_t c);
        return (int'(c) + 4) * 2;
    endfunction

    function automatic pix_t depth_max(dcode_t c);
        logic [PIX_W:0] one;
        one = (PIX_W + 1)'(1) << depth_bits(c);
        return pix_t'(one - 1'b1);
    endfunction

    function automatic pix_t round_clamp(sum_t s, pix_t mx);
        logic signed [SUM_W:0] t;
        t = ($signed({s[SUM_W-1], s}) + ROUND_ADD) >>> FRAC_W;
        if (t < 0)
            return '0;
        if (t > $signed({{(SUM_W + 1 - PIX_W){1'b0}}, mx}))
            return mx;
        return pix_t'(t);
    endfunction

endpackage

// File: rtl/ccm_cfg_regs.sv
module ccm_cfg_regs
    import ccm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    input  logic              frame_take,
    output cfg_t              cfg_now
);

    logic [BUS_DW-1:0] sh_bytes [N_COEF_BYTES];
    logic              sh_en;
    dcode_t            sh_dcode;
    cfg_t              shadow;
    cfg_t              active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_COEF_BYTES; i++)
                sh_bytes[i] <= '0;
            sh_en    <= 1'b0;
            sh_dcode <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_COEF_BYTES; i++)
                if (wr_addr == COEF_BASE + BUS_AW'(i))
                    sh_bytes[i] <= wr_data;
            if (wr_addr == CTRL_ADDR)
                sh_en <= wr_data[EN_BIT];
            if (wr_addr == DEPTH_ADDR)
                sh_dcode <= wr_data[DCODE_W-1:0];
        end
    end

    always_comb begin
        shadow.en    = sh_en;
        shadow.dcode = sh_dcode;
        for (int k = 0; k < N_COEF; k++)
            for (int b = 0; b < BYTES_PER_COEF; b++)
                shadow.m[k][b*BUS_DW +: BUS_DW] = sh_bytes[k*BYTES_PER_COEF + b];
    end

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= '0;
        else if (frame_take)
            active_q <= shadow;
    end

    // the frame-start pixel itself already sees the new set
    assign cfg_now = frame_take ? shadow : active_q;

    // R8: working set only moves on an accepted frame start
    a_r8_swap_at_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(frame_take));

    // R11: stray addresses leave the staged settings alone
    a_r11_stray_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr < COEF_BASE || wr_addr > DEPTH_ADDR)) |=> $stable(shadow));

    a_r11_idle_bus: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(shadow));

endmodule

// File: rtl/ccm_row_mac.sv
module ccm_row_mac
    import ccm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    input  coef_t [MAT_N-1:0]   coef,
    input  pix_t  [MAT_N-1:0]   pix,
    input  pix_t                mx_s2,
    output pix_t                res
);

    prod_t p1 [MAT_N];
    sum_t  acc;
    sum_t  s2;

    // stage 1: products, pixels taken as non-negative
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < MAT_N; c++)
                p1[c] <= '0;
        end else if (advance) begin
            for (int c = 0; c < MAT_N; c++)
                p1[c] <= $signed(coef[c]) * $signed({1'b0, pix[c]});
        end
    end

    always_comb begin
        acc = '0;
        for (int c = 0; c < MAT_N; c++)
            acc = acc + sum_t'(p1[c]);
    end

    // stage 2: accumulated row
    always_ff @(posedge clk) begin
        if (rst)
            s2 <= '0;
        else if (advance)
            s2 <= acc;
    end

    // stage 3: round and clamp
    always_ff @(posedge clk) begin
        if (rst)
            res <= '0;
        else if (advance)
            res <= round_clamp(s2, mx_s2);
    end

endmodule

// File: rtl/ccm_mac_pipe.sv
module ccm_mac_pipe
    import ccm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic fire,
    input  logic in_sof,
    input  rgb_t in_pix,
    input  cfg_t cfg,
    output logic out_valid,
    output logic out_sof,
    output rgb_t out_pix
);

    meta_t m1, m2, m3;
    pix_t [MAT_N-1:0] cols;
    pix_t res [MAT_N];

    assign cols = {in_pix.b, in_pix.g, in_pix.r};

    always_ff @(posedge clk) begin
        if (rst) begin
            m1 <= '0;
            m2 <= '0;
            m3 <= '0;
        end else if (advance) begin
            m1.v   <= fire;
            m1.sof <= fire & in_sof;
            m1.en  <= cfg.en;
            m1.mx  <= depth_max(cfg.dcode);
            m1.raw <= in_pix;
            m2     <= m1;
            m3     <= m2;
        end
    end

    generate
        for (genvar row = 0; row < MAT_N; row++) begin : g_row
            ccm_row_mac u_row (
                .clk     (clk),
                .rst     (rst),
                .advance (advance),
                .coef    (cfg.m[row*MAT_N +: MAT_N]),
                .pix     (cols),
                .mx_s2   (m2.mx),
                .res     (res[row])
            );
        end
    endgenerate

    assign out_valid = m3.v;
    assign out_sof   = m3.sof;
    assign out_pix   = m3.en ? rgb_t'{r: res[0], g: res[1], b: res[2]} : m3.raw;

    // R5: matrix results never exceed the depth they were computed for
    a_r5_within_depth: assert property (@(posedge clk) disable iff (rst)
        (m3.v && m3.en) |-> (res[0] <= m3.mx && res[1] <= m3.mx && res[2] <= m3.mx));

    // R9: frame marker only travels with a real pixel
    a_r9_sof_with_valid: assert property (@(posedge clk) disable iff (rst)
        m3.sof |-> m3.v);

endmodule

// File: rtl/ccm_unit.sv
module ccm_unit
    import ccm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sof,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);

    logic advance;
    logic fire;
    logic frame_take;
    cfg_t cfg_now;
    rgb_t in_pix;
    rgb_t out_pix;

    assign advance    = !out_valid || out_ready;
    assign in_ready   = advance;
    assign fire       = in_valid && advance;
    assign frame_take = fire && in_sof;
    assign in_pix     = rgb_t'{r: in_r, g: in_g, b: in_b};

    ccm_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_take (frame_take),
        .cfg_now    (cfg_now)
    );

    ccm_mac_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .fire      (fire),
        .in_sof    (in_sof),
        .in_pix    (in_pix),
        .cfg       (cfg_now),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_pix   (out_pix)
    );

    assign out_r = out_pix.r;
    assign out_g = out_pix.g;
    assign out_b = out_pix.b;

    // R10: a refused output stays put
    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g)
                                       && $stable(out_b) && $stable(out_sof)));

    // R10: a valid output only disappears after it was taken
    a_r10_leave_on_take: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready));

endmodule

// File: tb/tb_ccm_unit.sv
module tb_ccm_unit;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;
    localparam int PW = ccm_pkg::PIX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
    logic in_ready, out_valid, out_sof;
    logic [PW-1:0] in_r = '0, in_g = '0, in_b = '0;
    logic [PW-1:0] out_r, out_g, out_b;

    ccm_unit dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    always #(HALF) clk = ~clk;

    typedef struct {
        int    r, g, b;
        bit    sof;
        int    cyc;
        bit    lat;
        string tag;
    } exp_t;

    exp_t exq[$];
    int checks = 0, fails = 0, cyc = 0;
    bit rdy_random = 1'b0;
    logic [15:0] sh [9];
    logic [15:0] act [9];
    bit en_s = 0, en_a = 0;
    logic [1:0] dc_s = '0, dc_a = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always begin
        @(posedge clk); #1;
        out_ready = rdy_random ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actv, expv);
        end
    endtask

    function automatic int dmax(logic [1:0] c);
        return (1 << ((int'(c) + 4) * 2)) - 1;
    endfunction

    function automatic int chan(int row, int r, int g, int b);
        longint c0, c1, c2, acc;
        c0 = $signed(act[row*3]);
        c1 = $signed(act[row*3+1]);
        c2 = $signed(act[row*3+2]);
        acc = c0 * r + c1 * g + c2 * b;
        acc = (acc + 256) >>> 9;
        if (acc < 0) acc = 0;
        if (acc > dmax(dc_a)) acc = dmax(dc_a);
        return int'(acc);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        int idx;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a >= 8'hD0 && a <= 8'hE1) begin
            idx = int'(a) - 'hD0;
            if (idx % 2 == 1) sh[idx/2][15:8] = d;
            else              sh[idx/2][7:0]  = d;
        end else if (a == 8'hE2) en_s = d[1];
        else if (a == 8'hE3)    dc_s = d[1:0];
    endtask

    task automatic set_coef(input int k, input logic [15:0] v);
        wr(8'(8'hD0 + 2*k), v[7:0]);
        wr(8'(8'hD1 + 2*k), v[15:8]);
    endtask

    task automatic clear_matrix();
        for (int k = 0; k < 9; k++) set_coef(k, 16'h0000);
    endtask

    task automatic send(input int r, input int g, input int b, input bit sof,
                        input string tag, input bit lat = 0);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof;
        in_r = PW'(r); in_g = PW'(g); in_b = PW'(b);
        forever begin
            #(HALF - 1);
            if (in_ready) break;
            @(negedge clk);
        end
        if (sof) begin
            for (int k = 0; k < 9; k++) act[k] = sh[k];
            en_a = en_s; dc_a = dc_s;
        end
        if (en_a) begin
            e.r = chan(0, r, g, b); e.g = chan(1, r, g, b); e.b = chan(2, r, g, b);
        end else begin
            e.r = r; e.g = g; e.b = b;
        end
        e.sof = sof; e.cyc = cyc; e.lat = lat; e.tag = tag;
        exq.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        bit prev_stall = 0;
        logic [PW-1:0] pr = '0, pg = '0, pb = '0;
        logic ps = 0;
        exp_t e;
        forever begin
            @(negedge clk); #(HALF - 1);
            if (!rst) begin
                if (prev_stall) begin
                    chk(out_valid === 1'b1, "R10", "valid held", out_valid, 1);
                    chk(out_r == pr && out_g == pg && out_b == pb && out_sof == ps,
                        "R10", "outputs held", out_r, pr);
                end
                if (out_valid && !out_ready)
                    chk(in_ready === 1'b0, "R10", "in_ready during stall", in_ready, 0);
                prev_stall = out_valid && !out_ready;
                pr = out_r; pg = out_g; pb = out_b; ps = out_sof;
                if (out_valid && out_ready) begin
                    if (exq.size() == 0) begin
                        chk(1'b0, "R9", "unexpected output", 1, 0);
                    end else begin
                        e = exq.pop_front();
                        chk(out_r == PW'(e.r), e.tag, "red", out_r, e.r);
                        chk(out_g == PW'(e.g), e.tag, "green", out_g, e.g);
                        chk(out_b == PW'(e.b), e.tag, "blue", out_b, e.b);
                        chk(out_sof == e.sof, "R9", "sof alignment", out_sof, e.sof);
                        if (e.lat) chk(cyc - e.cyc == 3, "R9", "latency", cyc - e.cyc, 3);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 9; k++) begin sh[k] = '0; act[k] = '0; end
        repeat (4) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk); #1;
        // R1: reset state at the ports
        chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // R7: bypass by default, no clamping even above the 8-bit depth
        send(300, 5, 16000, 1, "R7");
        send(0, 255, 1234, 0, "R7");
        // R1: enabled with reset coefficients gives zeros
        wr(8'hE2, 8'h02);
        send(100, 50, 20, 1, "R1");

        // R2/R3: identity at 8 bits
        for (int k = 0; k < 3; k++) set_coef(4 * k, 16'h0200);
        send(10, 20, 30, 1, "R2");
        for (int i = 0; i < 6; i++)
            send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255), 0, "R3");

        // R3/R5/R6: general matrix, 10-bit depth, random backpressure
        rdy_random = 1'b1;
        wr(8'hE3, 8'h01);
        set_coef(0, 16'h0300); set_coef(1, 16'hFF80); set_coef(2, 16'hFF80);
        set_coef(3, 16'hFFC0); set_coef(4, 16'h0280); set_coef(5, 16'hFFC0);
        set_coef(6, 16'h0000); set_coef(7, 16'hFF00); set_coef(8, 16'h0300);
        send(512, 512, 512, 1, "R3");
        for (int i = 0; i < 30; i++)
            send($urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023), 0, "R3");

        // R4: rounding boundaries at 8 bits
        wr(8'hE3, 8'h00);
        clear_matrix();
        set_coef(0, 16'h0100);
        set_coef(8, 16'h0001);
        send(1, 0, 255, 1, "R4");
        send(2, 0, 256 - 1, 0, "R4");
        send(3, 0, 0, 0, "R4");
        send(5, 0, 0, 0, "R4");

        // R5: clamp high and low at 8 bits
        clear_matrix();
        set_coef(0, 16'h0400);
        set_coef(4, 16'hFE00);
        set_coef(8, 16'h0200);
        send(200, 10, 77, 1, "R5");
        send(100, 255, 255, 0, "R5");
        // R6: 14-bit and 12-bit depths
        wr(8'hE3, 8'h03);
        send(9000, 3, 16383, 1, "R6");
        send(4000, 0, 12000, 0, "R6");
        wr(8'hE3, 8'h02);
        send(3000, 0, 4095, 1, "R6");

        // R8: mid-frame write waits for the next frame start
        wr(8'hE3, 8'h03);
        send(1000, 0, 500, 1, "R8");
        set_coef(0, 16'h0200);
        send(1000, 0, 500, 0, "R8");
        send(1001, 0, 501, 0, "R8");
        send(1000, 0, 500, 1, "R8");

        // R11: stray writes change nothing
        wr(8'hCF, 8'hFF);
        wr(8'hE4, 8'hFF);
        wr(8'h00, 8'h55);
        send(1234, 20, 99, 1, "R11");
        send(8000, 7, 9000, 0, "R11");

        // R9: latency with ready held high
        rdy_random = 1'b0;
        repeat (3) @(posedge clk);
        send(11, 22, 33, 1, "R9", 1);
        send(44, 55, 66, 0, "R9", 1);

        // R7: disabling returns to pass-through at the next frame
        wr(8'hE2, 8'h00);
        send(16383, 2, 3, 1, "R7");
        send(7, 8, 9, 0, "R7");

        while (exq.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule